// File: doc/BRIEF.md
# Multi-rate I2S clock master

This block is the single source of audio timing for an array of converters inside an FPGA. It has two reference inputs, one for each of the 44.1 kHz and 48 kHz families. Each reference arrives as a tick strobe that is synchronous to the fabric clock, with one tick for each half period of 256 × 192 kHz (or 256 × 176.4 kHz). From the selected reference it derives a 256 × Fs master clock, a 64 × Fs bit clock and a frame clock, all as registered levels. It also shifts out one 32-bit stereo pair per frame in standard I2S framing.

A host can ask for a new sample rate with a one-cycle request and a rate code. The block then mutes, lets the current frame end, and stops the clocks low for one cycle. It then selects the other reference and loads the new divider, runs 16 muted settling frames (a parameter), and finally raises ready. While ready is high, the serializer pulls one stereo pair per frame through a valid/ready handshake.

Top module: `i2s_rate_master`

## Requirements
- R1: During and right after reset, ready is low and mute is high. The clocks start at the default rate (parameter DEF_CODE), and ready rises only after the settling count.
- R2: Rate codes are: 0 = 44.1 kHz, 1 = 48 kHz, 2 = 88.2 kHz, 3 = 96 kHz, 4 = 176.4 kHz, 5 = 192 kHz. Bit 0 of the code selects the reference (1 = 48 kHz family, ref48_tick). Bits 2:1 select the master clock divider (0 → 4, 1 → 2, 2 → 1). One master clock half period lasts that many ticks of the selected reference.
- R3: Each bit clock period holds 4 master clock periods, and each frame clock period holds 64 bit clock periods (256 master clock periods).
- R4: lrclk is low for the left slot and high for the right slot. lrclk and sdata change only when bclk falls. Each slot carries 32 bits MSB first, and the MSB appears one bit clock after the lrclk transition.
- R5: While ready is high, in_ready is high for exactly one fabric cycle per frame: the cycle in which bclk falls to start the left MSB. The pair on in_left/in_right is taken in that cycle if in_valid is high.
- R6: If in_valid is low in the in_ready cycle, the frame that follows carries zero in both slots.
- R7: A supported request made while ready is high drops ready, raises mute and forces sdata to zero from the next cycle.
- R8: After a request, the clocks keep running to the end of the current frame. They then hold mclk, bclk and lrclk low for one cycle and restart from the new reference and divider.
- R9: After the restart, mute stays high for SETTLE_FRAMES full frames. Ready then rises at a frame boundary.
- R10: A request with code 6 or 7, or any request made while ready is low, is ignored: the rate, ready and mute do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| ref44_tick | input | 1 | Tick strobe of the 44.1 kHz family reference |
| ref48_tick | input | 1 | Tick strobe of the 48 kHz family reference |
| rate_req | input | 1 | One-cycle rate change request |
| rate_code | input | 3 | Requested rate code |
| in_valid | input | 1 | Stereo pair available |
| in_ready | output | 1 | Pair taken this cycle if in_valid |
| in_left | input | 32 | Left sample |
| in_right | input | 32 | Right sample |
| mclk | output | 1 | Master clock, 256 × Fs |
| bclk | output | 1 | Bit clock, 64 × Fs |
| lrclk | output | 1 | Frame clock, low = left |
| sdata | output | 1 | Serial data |
| ready | output | 1 | Running at the requested rate, unmuted |
| mute | output | 1 | Output forced to zero |

## Verification
The bench builds the block with SETTLE_FRAMES = 2 and DEF_CODE = 5 (192 kHz). Short settling windows and a fast start let several full rate switches fit in one run, covering both reference families and all three dividers. The two tick strobes use different densities (two of three cycles for the 48 kHz family, every second cycle for the 44.1 kHz family), so a wrongly chosen reference shows up as a wrong clock period. A behavioural model derives every output from a half-period count. It is compared on every cycle, including the drain, stop and settle phases and an underflow window.

// File: rtl/i2s_rate_master.sv
module i2s_rate_master #(
  parameter int          SETTLE_FRAMES = 16,
  parameter logic [2:0]  DEF_CODE      = 3'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ref44_tick,
  input  logic        ref48_tick,
  input  logic        rate_req,
  input  logic [2:0]  rate_code,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_left,
  input  logic [31:0] in_right,
  output logic        mclk,
  output logic        bclk,
  output logic        lrclk,
  output logic        sdata,
  output logic        ready,
  output logic        mute
);
  localparam int SLOT = 32;
  localparam int FRM  = 2 * SLOT;
  localparam int CW   = $clog2(SETTLE_FRAMES + 1);

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_SWITCH, S_SETTLE} st_t;

  function automatic logic [2:0] div_of(input logic [2:0] c);
    case (c[2:1])
      2'd0:    div_of = 3'd4;
      2'd1:    div_of = 3'd2;
      default: div_of = 3'd1;
    endcase
  endfunction

  st_t            st;
  logic           fam;
  logic [2:0]     div, pend;
  logic [1:0]     pre;
  logic [8:0]     q;
  logic [CW-1:0]  frm;
  logic [FRM-1:0] sh;

  wire code_ok = rate_code < 3'd6;
  wire tick    = fam ? ref48_tick : ref44_tick;
  wire adv     = (st != S_SWITCH) && tick && ({1'b0, pre} == div - 3'd1);
  wire wrap    = adv && (q == 9'd511);
  wire load    = adv && (q == 9'd7);

  assign in_ready = (st == S_RUN) && load;
  assign mclk     = q[0];
  assign bclk     = q[2];
  assign lrclk    = q[8];
  assign ready    = (st == S_RUN);
  assign mute     = (st != S_RUN);
  assign sdata    = sh[FRM-1] && (st == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_SETTLE;
      fam  <= DEF_CODE[0];
      div  <= div_of(DEF_CODE);
      pend <= DEF_CODE;
      pre  <= '0;
      q    <= '0;
      frm  <= '0;
      sh   <= '0;
    end else begin
      if (st != S_SWITCH && tick) pre <= adv ? 2'd0 : pre + 2'd1;
      if (adv) q <= q + 9'd1;
      if (load)
        sh <= (in_ready && in_valid) ? {in_left, in_right} : '0;
      else if (adv && q[2:0] == 3'd7)
        sh <= {sh[FRM-2:0], 1'b0};
      case (st)
        S_RUN:    if (rate_req && code_ok) begin
                    pend <= rate_code;
                    st   <= S_DRAIN;
                  end
        S_DRAIN:  if (wrap) st <= S_SWITCH;
        S_SWITCH: begin
                    fam <= pend[0];
                    div <= div_of(pend);
                    pre <= '0;
                    q   <= '0;
                    frm <= '0;
                    st  <= S_SETTLE;
                  end
        default:  if (wrap) begin
                    if (frm == CW'(SETTLE_FRAMES - 1)) st <= S_RUN;
                    else frm <= frm + 1'b1;
                  end
      endcase
    end
  end
endmodule

// File: rtl/i2s_rate_master_chk.sv
module i2s_rate_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       mclk,
  input logic       bclk,
  input logic       lrclk,
  input logic       sdata,
  input logic       ready,
  input logic       mute,
  input logic       in_ready,
  input logic       rate_req,
  input logic [2:0] rate_code
);
  p_lr_on_bclk_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk));

  p_data_on_bclk_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> ($fell(bclk) || $rose(mute)));

  p_bclk_follows_mclk_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(bclk) |-> !$stable(mclk));

  p_muted_data_zero_r7: assert property (@(posedge clk) disable iff (rst)
    mute |-> !sdata);

  p_pull_only_running_r5: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> ready);

  p_ready_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (!lrclk && !bclk && !mclk));

  p_bad_code_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (ready && rate_req && rate_code > 3'd5) |=> ready);
endmodule

bind i2s_rate_master i2s_rate_master_chk u_chk (
  .clk(clk), .rst(rst), .mclk(mclk), .bclk(bclk), .lrclk(lrclk),
  .sdata(sdata), .ready(ready), .mute(mute), .in_ready(in_ready),
  .rate_req(rate_req), .rate_code(rate_code)
);

// File: tb/sim_i2s_rate_master.sv
module sim_i2s_rate_master;
  localparam int         SF  = 2;
  localparam logic [2:0] DEF = 3'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic ref44_tick = 1'b0, ref48_tick = 1'b0;
  logic rate_req = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic in_valid = 1'b1;
  logic [31:0] in_left = '0, in_right = '0;
  logic in_ready, mclk, bclk, lrclk, sdata, ready, mute;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2s_rate_master #(.SETTLE_FRAMES(SF), .DEF_CODE(DEF)) u0 (
    .clk(clk), .rst(rst), .ref44_tick(ref44_tick), .ref48_tick(ref48_tick),
    .rate_req(rate_req), .rate_code(rate_code), .in_valid(in_valid),
    .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .mclk(mclk), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .ready(ready), .mute(mute));

  // behavioural reference
  int m_st, m_fam, m_div, m_pre, m_q, m_frm, m_pend, k;
  logic [31:0] m_L, m_R;

  function automatic int divf(input int c);
    return (c / 2 == 0) ? 4 : (c / 2 == 1) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 3; m_pend = DEF; m_fam = DEF % 2; m_div = divf(DEF);
      m_pre = 0; m_q = 0; m_frm = 0; m_L = 0; m_R = 0; k = 0;
    end else begin
      bit tk, adv, wr, ld;
      tk  = m_fam ? ref48_tick : ref44_tick;
      adv = (m_st != 2) && tk && (m_pre == m_div - 1);
      wr  = adv && m_q == 511;
      ld  = adv && m_q == 7;
      if (m_st != 2 && tk) m_pre = adv ? 0 : m_pre + 1;
      if (ld) begin
        if (m_st == 0 && in_valid) begin m_L = in_left; m_R = in_right; k++; end
        else begin m_L = 0; m_R = 0; end
      end
      if (adv) m_q = (m_q + 1) % 512;
      case (m_st)
        0: if (rate_req && rate_code <= 5) begin m_pend = rate_code; m_st = 1; end
        1: if (wr) m_st = 2;
        2: begin
             m_fam = m_pend % 2; m_div = divf(m_pend);
             m_pre = 0; m_q = 0; m_frm = 0; m_st = 3;
           end
        default: if (wr) begin
                   if (m_frm == SF - 1) m_st = 0; else m_frm++;
                 end
      endcase
    end
  end

  // input drivers
  always @(posedge clk) begin
    #1;
    cyc++;
    ref48_tick = (cyc % 3) != 0;
    ref44_tick = (cyc % 2) == 0;
    in_left    = {k[15:0], ~k[15:0]} ^ 32'h5A5A_1234;
    in_right   = in_left * 32'd3 + 32'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_data();
    int b;
    b = m_q / 8;
    if (m_st != 0) return 1'b0;
    if (b == 0) return m_R[0];
    if (b <= 32) return m_L[32 - b];
    return m_R[64 - b];
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit tk, e_ir;
      tk   = m_fam ? ref48_tick : ref44_tick;
      e_ir = (m_st == 0) && tk && (m_pre == m_div - 1) && (m_q == 7);
      chk(mclk  == (m_q % 2),       "R2 R8 mclk",  mclk,  m_q % 2);
      chk(bclk  == ((m_q / 4) % 2), "R3 R8 bclk",  bclk,  (m_q / 4) % 2);
      chk(lrclk == (m_q / 256),     "R3 R4 lrclk", lrclk, m_q / 256);
      chk(sdata == exp_data(),      "R4 R6 R7 sdata", sdata, exp_data());
      chk(ready == (m_st == 0),     "R1 R9 R10 ready", ready, m_st == 0);
      chk(mute  == (m_st != 0),     "R7 R9 mute",  mute,  m_st != 0);
      chk(in_ready == e_ir,         "R5 in_ready", in_ready, e_ir);
    end
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] c);
    @(posedge clk); #1.5;
    rate_code = c; rate_req = 1'b1;
    @(posedge clk); #1.5;
    rate_req = 1'b0;
  endtask

  task automatic frame_counts(output int nm, output int nb, output int npull);
    logic pl, pm, pb;
    pl = lrclk;
    @(negedge clk);
    while (!(pl && !lrclk)) begin pl = lrclk; @(negedge clk); end
    nm = 0; nb = 0; npull = 0; pm = mclk; pb = bclk; pl = lrclk;
    @(negedge clk);
    while (!(pl && !lrclk)) begin
      if (mclk && !pm) nm++;
      if (bclk && !pb) nb++;
      if (in_ready) npull++;
      pm = mclk; pb = bclk; pl = lrclk;
      @(negedge clk);
    end
  endtask

  task automatic measure(input string tag);
    int nm, nb, np;
    frame_counts(nm, nb, np);
    chk(nm == 256, {"R3 mclk per frame ", tag}, nm, 256);
    chk(nb == 64,  {"R3 bclk per frame ", tag}, nb, 64);
    chk(np == 1,   {"R5 pulls per frame ", tag}, np, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1.5 rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", ready, 0);
    chk(mute  == 1'b1, "R1 mute after reset",  mute,  1);
    request(3'd0);                       // ignored while settling
    wait_ready();
    measure("192k");

    request(3'd7);                       // unsupported
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R10 bad code keeps ready", ready, 1);
    measure("after bad code");

    request(3'd0);                       // to 44.1 kHz
    @(negedge clk);
    chk(mute == 1'b1, "R7 mute right after request", mute, 1);
    chk(sdata == 1'b0, "R7 data zero while muted", sdata, 0);
    request(3'd3);                       // ignored while draining
    wait_ready();
    measure("44.1k");

    in_valid = 1'b0;                     // underflow window
    measure("underflow");
    in_valid = 1'b1;

    request(3'd3);                       // 96 kHz
    wait_ready();
    measure("96k");
    request(3'd2);                       // 88.2 kHz
    wait_ready();
    measure("88.2k");
    request(3'd4);                       // 176.4 kHz
    wait_ready();
    measure("176.4k");
    request(3'd1);                       // 48 kHz
    wait_ready();
    measure("48k");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule